// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block moves four IO channels between a frozen state, where pad drivers are parked and held, and a thawed, operational state. It does this by stepping every channel's control lines through a fixed order of edges, with a minimum wait between steps. Channels 0 to 2 are plain banks with five lines each: slew enable, weak pullup, tristate and bus-hold, all active low, and an active-high configuration-done line. Channel 3 is an extended bank. It has the same five lines plus a regulator reset, a termination reset, a DLL reset and a calibration/bias enable. Its thaw includes two waits that are counted on a synchronized internal-oscillator tick rather than on the system clock.

A freeze or thaw request is taken only when the source select names this sequencer. While a sequence runs, `busy` is high. When the sequence ends, `done` pulses for one cycle. The plain channels are always sequenced first, in ascending order, and channel 3 comes last. Each channel's frozen flag changes on the same edge as that channel's final step. Short and long minimum waits are given in nanoseconds and converted to system-clock cycles, rounding up, from a clock-period parameter.

States of the controller:
- `S_IDLE`: waits for a request.
- Plain-channel freeze: `S_FZ_WEAK` then `S_FZ_HOLD`.
- Extended-channel freeze: `S_FZX_WEAK`, `S_FZX_HOLD`, `S_FZX_CORE`.
- Plain-channel thaw: `S_TH_HOLD`, `S_TH_WEAK`, `S_TH_SLEW`.
- Extended-channel thaw: `S_THX_DLL`, `S_THX_CAL`, `S_THX_HOLD`, `S_THX_WEAK`, `S_THX_REG`, `S_THX_SLEW`.
- `S_DONE`: the final state of every sequence.

Transitions:
- A step state performs its action when the wait timer has expired and the select is high, then moves to the next state in the lists above.
- After the last plain channel, the controller moves to the extended states.
- The final extended step leads to `S_DONE`, and `S_DONE` always returns to `S_IDLE`.

Top module: `frz_io_sequencer`

## Requirements
- R1: After reset every plain pad line and configuration-done are 0, regulator, termination and DLL resets are 1, calibration enable is 0, `frozen` is 4'b1111, and `busy` and `done` are 0.
- R2: Freezing a plain channel first drives its slew, pullup and tristate lines low on one edge. At least 4 cycles (20 ns at 200 MHz) later, bus-hold and configuration-done go low together.
- R3: Freezing channel 3 first drives slew, pullup and tristate low. At least 4 cycles later, bus-hold and configuration-done go low on the same edge that raises regulator and termination reset. A later edge then drives calibration enable low and raises DLL reset together.
- R4: Thawing a plain channel raises bus-hold and configuration-done together. At least 4 cycles later it raises pullup and tristate together. At least 4 cycles after that it raises slew.
- R5: Thawing channel 3 first clears DLL reset. At least 8 cycles (40 ns) later it raises calibration enable. After at least 1000 oscillator ticks it raises bus-hold and configuration-done and clears termination reset, all on one edge.
- R6: At least 33 ticks after that, channel 3 raises pullup and tristate. At least 8 cycles later it clears regulator reset. At least 8 cycles after that it raises slew.
- R7: Channels are handled in the order 0, 1, 2, 3, and no channel starts before the previous one has finished. A channel's `frozen` bit is set by its freeze step that drives bus-hold low for a plain channel, or DLL reset high for channel 3. It is cleared by the channel's final slew release.
- R8: `busy` is 1 from the cycle after a request is accepted until the end of the sequence. `done` is a single-cycle pulse with `busy` low. A request that arrives while `busy` is high changes nothing.
- R9: A freeze request while `frozen` is 4'b1111, or a thaw request while `frozen` is 4'b0000, is ignored: no output changes and `busy` stays 0.
- R10: While `src_sel` is 0, requests are ignored, every control output holds its value and a running sequence makes no progress. The sequence resumes once `src_sel` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | 1 selects this sequencer as the control source |
| freeze_req | input | 1 | Request to freeze all channels |
| thaw_req | input | 1 | Request to thaw all channels |
| osc_tick | input | 1 | Synchronized one-cycle pulse per internal-oscillator cycle |
| slew_n | output | 4 | Per-channel slew enable, active low |
| pullup_n | output | 4 | Per-channel weak pullup, active low |
| tristate_n | output | 4 | Per-channel tristate, active low |
| bushold_n | output | 4 | Per-channel bus-hold, active low |
| cfg_done | output | 4 | Per-channel configuration done, active high |
| reg_rst | output | 1 | Channel 3 regulator reset, active high |
| term_rst | output | 1 | Channel 3 termination reset, active high |
| dll_rst | output | 1 | Channel 3 DLL reset, active high |
| cal_en | output | 1 | Channel 3 calibration-start/bias enable, active high |
| frozen | output | 4 | Per-channel frozen flag |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench records the cycle and the oscillator-tick count at which every line and flag changes, then checks order, coincidence and minimum spacing. This catches a design that merges two steps on one edge, swaps the pullup and slew releases, or counts the 1000-tick calibration wait in clock cycles, which would finish far too early when ticks arrive every third cycle. It injects the opposite request in the middle of a run and repeats requests that must be ignored. A design that restarted or reversed would show stray edges or a second `busy` period. It also drops `src_sel` in the middle of a thaw. A design that kept counting or kept driving would change outputs or raise `done` while deselected.

// File: rtl/frz_pkg.sv
package frz_pkg;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_FZ_WEAK,
        ACT_FZ_HOLD,
        ACT_FZ_CORE,
        ACT_TH_HOLD,
        ACT_TH_WEAK,
        ACT_TH_SLEW,
        ACT_TH_DLL,
        ACT_TH_CAL,
        ACT_TH_REG
    } act_t;

    typedef struct packed {
        logic slew_n;
        logic pullup_n;
        logic tristate_n;
        logic bushold_n;
        logic cfg_done;
    } pad_t;

    typedef struct packed {
        logic reg_rst;
        logic term_rst;
        logic dll_rst;
        logic cal_en;
    } xctl_t;

    localparam pad_t  PAD_FROZEN  = '0;
    localparam xctl_t XCTL_FROZEN = '{reg_rst: 1'b1, term_rst: 1'b1, dll_rst: 1'b1, cal_en: 1'b0};

    // minimum wait in ns -> clock cycles, rounded up, never below one
    function automatic int cyc_ceil(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/frz_wait_timer.sv
module frz_wait_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic          use_tick,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic          tick_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            tick_mode <= 1'b0;
        end else if (run) begin
            if (load) begin
                cnt       <= load_val;
                tick_mode <= use_tick;
            end else if (cnt != '0 && (!tick_mode || tick)) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expired = (cnt == '0);

    // R5
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && tick_mode && !tick) |=> $stable(cnt));

    // R10
    timer_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> $stable(cnt));

endmodule

// File: rtl/frz_pad_bank.sv
module frz_pad_bank
    import frz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  act_t act,
    output pad_t pad
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad <= PAD_FROZEN;
        end else if (en) begin
            unique case (act)
                ACT_FZ_WEAK: begin
                    pad.slew_n     <= 1'b0;
                    pad.pullup_n   <= 1'b0;
                    pad.tristate_n <= 1'b0;
                end
                ACT_FZ_HOLD: begin
                    pad.bushold_n <= 1'b0;
                    pad.cfg_done  <= 1'b0;
                end
                ACT_TH_HOLD: begin
                    pad.bushold_n <= 1'b1;
                    pad.cfg_done  <= 1'b1;
                end
                ACT_TH_WEAK: begin
                    pad.pullup_n   <= 1'b1;
                    pad.tristate_n <= 1'b1;
                end
                ACT_TH_SLEW: pad.slew_n <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/frz_ext_ctl.sv
module frz_ext_ctl
    import frz_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  act_t  act,
    output xctl_t xc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xc <= XCTL_FROZEN;
        end else if (en) begin
            unique case (act)
                ACT_FZ_HOLD: begin
                    xc.reg_rst  <= 1'b1;
                    xc.term_rst <= 1'b1;
                end
                ACT_FZ_CORE: begin
                    xc.cal_en  <= 1'b0;
                    xc.dll_rst <= 1'b1;
                end
                ACT_TH_DLL:  xc.dll_rst  <= 1'b0;
                ACT_TH_CAL:  xc.cal_en   <= 1'b1;
                ACT_TH_HOLD: xc.term_rst <= 1'b0;
                ACT_TH_REG:  xc.reg_rst  <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/frz_seq_ctrl.sv
module frz_seq_ctrl
    import frz_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int CW           = 10,
    parameter int SHORT_CYC    = 4,
    parameter int LONG_CYC     = 8,
    parameter int CAL_TICKS    = 1000,
    parameter int SETTLE_TICKS = 33
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           src_sel,
    input  logic           freeze_req,
    input  logic           thaw_req,
    input  logic           tmr_expired,
    output act_t           act,
    output logic [NCH-1:0] act_ch,
    output logic           act_fire,
    output logic           tmr_load,
    output logic           tmr_use_tick,
    output logic [CW-1:0]  tmr_val,
    output logic [NCH-1:0] frozen,
    output logic           busy,
    output logic           done
);
    localparam int CHW  = (NCH > 2) ? $clog2(NCH) : 1;
    localparam int LAST = NCH - 1;

    typedef enum logic [4:0] {
        S_IDLE,
        S_FZ_WEAK, S_FZ_HOLD,
        S_FZX_WEAK, S_FZX_HOLD, S_FZX_CORE,
        S_TH_HOLD, S_TH_WEAK, S_TH_SLEW,
        S_THX_DLL, S_THX_CAL, S_THX_HOLD, S_THX_WEAK, S_THX_REG, S_THX_SLEW,
        S_DONE
    } state_t;

    state_t           state, state_nxt;
    logic [CHW-1:0]   ch, ch_nxt;
    logic [NCH-1:0]   frz_nxt;
    logic             step;
    logic             last_plain;

    assign step       = src_sel && tmr_expired;
    assign last_plain = (ch == CHW'(LAST - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            ch     <= '0;
            frozen <= '1;
        end else begin
            state  <= state_nxt;
            ch     <= ch_nxt;
            frozen <= frz_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        ch_nxt    = ch;
        frz_nxt   = frozen;
        unique case (state)
            S_IDLE: begin
                if (src_sel) begin
                    if (freeze_req && !(&frozen)) begin
                        state_nxt = S_FZ_WEAK;
                        ch_nxt    = '0;
                    end else if (thaw_req && (|frozen)) begin
                        state_nxt = S_TH_HOLD;
                        ch_nxt    = '0;
                    end
                end
            end
            S_FZ_WEAK:  if (step) state_nxt = S_FZ_HOLD;
            S_FZ_HOLD: begin
                if (step) begin
                    frz_nxt[ch] = 1'b1;
                    if (last_plain) begin
                        state_nxt = S_FZX_WEAK;
                    end else begin
                        state_nxt = S_FZ_WEAK;
                        ch_nxt    = ch + 1'b1;
                    end
                end
            end
            S_FZX_WEAK: if (step) state_nxt = S_FZX_HOLD;
            S_FZX_HOLD: if (step) state_nxt = S_FZX_CORE;
            S_FZX_CORE: begin
                if (step) begin
                    frz_nxt[LAST] = 1'b1;
                    state_nxt     = S_DONE;
                end
            end
            S_TH_HOLD:  if (step) state_nxt = S_TH_WEAK;
            S_TH_WEAK:  if (step) state_nxt = S_TH_SLEW;
            S_TH_SLEW: begin
                if (step) begin
                    frz_nxt[ch] = 1'b0;
                    if (last_plain) begin
                        state_nxt = S_THX_DLL;
                    end else begin
                        state_nxt = S_TH_HOLD;
                        ch_nxt    = ch + 1'b1;
                    end
                end
            end
            S_THX_DLL:  if (step) state_nxt = S_THX_CAL;
            S_THX_CAL:  if (step) state_nxt = S_THX_HOLD;
            S_THX_HOLD: if (step) state_nxt = S_THX_WEAK;
            S_THX_WEAK: if (step) state_nxt = S_THX_REG;
            S_THX_REG:  if (step) state_nxt = S_THX_SLEW;
            S_THX_SLEW: begin
                if (step) begin
                    frz_nxt[LAST] = 1'b0;
                    state_nxt     = S_DONE;
                end
            end
            S_DONE:     state_nxt = S_IDLE;
            default:    state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        act          = ACT_NONE;
        act_ch       = '0;
        tmr_use_tick = 1'b0;
        tmr_val      = '0;
        unique case (state)
            S_FZ_WEAK: begin
                act = ACT_FZ_WEAK; act_ch = NCH'(1) << ch; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_FZ_HOLD: begin
                act = ACT_FZ_HOLD; act_ch = NCH'(1) << ch; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_FZX_WEAK: begin
                act = ACT_FZ_WEAK; act_ch[LAST] = 1'b1; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_FZX_HOLD: begin
                act = ACT_FZ_HOLD; act_ch[LAST] = 1'b1; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_FZX_CORE: begin
                act = ACT_FZ_CORE; act_ch[LAST] = 1'b1;
            end
            S_TH_HOLD: begin
                act = ACT_TH_HOLD; act_ch = NCH'(1) << ch; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_TH_WEAK: begin
                act = ACT_TH_WEAK; act_ch = NCH'(1) << ch; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_TH_SLEW: begin
                act = ACT_TH_SLEW; act_ch = NCH'(1) << ch; tmr_val = CW'(SHORT_CYC - 1);
            end
            S_THX_DLL: begin
                act = ACT_TH_DLL; act_ch[LAST] = 1'b1; tmr_val = CW'(LONG_CYC - 1);
            end
            S_THX_CAL: begin
                act = ACT_TH_CAL; act_ch[LAST] = 1'b1;
                tmr_val = CW'(CAL_TICKS); tmr_use_tick = 1'b1;
            end
            S_THX_HOLD: begin
                act = ACT_TH_HOLD; act_ch[LAST] = 1'b1;
                tmr_val = CW'(SETTLE_TICKS); tmr_use_tick = 1'b1;
            end
            S_THX_WEAK: begin
                act = ACT_TH_WEAK; act_ch[LAST] = 1'b1; tmr_val = CW'(LONG_CYC - 1);
            end
            S_THX_REG: begin
                act = ACT_TH_REG; act_ch[LAST] = 1'b1; tmr_val = CW'(LONG_CYC - 1);
            end
            S_THX_SLEW: begin
                act = ACT_TH_SLEW; act_ch[LAST] = 1'b1;
            end
            default: ;
        endcase
    end

    assign act_fire = step && (act != ACT_NONE);
    assign tmr_load = act_fire;
    assign busy     = (state != S_IDLE) && (state != S_DONE);
    assign done     = (state == S_DONE);

    // R9
    freeze_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && (&frozen) && !thaw_req) |=> state == S_IDLE);

    // R9
    thaw_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && frozen == '0 && !freeze_req) |=> state == S_IDLE);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(frozen ^ $past(frozen)) <= 1);

    // R10
    stall_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && state != S_IDLE) |=> $stable(state));

endmodule

// File: rtl/frz_io_sequencer.sv
module frz_io_sequencer
    import frz_pkg::*;
#(
    parameter int N_SIMPLE     = 3,
    parameter int CLK_PS       = 5000,
    parameter int SHORT_NS     = 20,
    parameter int LONG_NS      = 40,
    parameter int CAL_TICKS    = 1000,
    parameter int SETTLE_TICKS = 33
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_sel,
    input  logic                freeze_req,
    input  logic                thaw_req,
    input  logic                osc_tick,
    output logic [N_SIMPLE:0]   slew_n,
    output logic [N_SIMPLE:0]   pullup_n,
    output logic [N_SIMPLE:0]   tristate_n,
    output logic [N_SIMPLE:0]   bushold_n,
    output logic [N_SIMPLE:0]   cfg_done,
    output logic                reg_rst,
    output logic                term_rst,
    output logic                dll_rst,
    output logic                cal_en,
    output logic [N_SIMPLE:0]   frozen,
    output logic                busy,
    output logic                done
);
    localparam int NCH       = N_SIMPLE + 1;
    localparam int SHORT_CYC = cyc_ceil(SHORT_NS, CLK_PS);
    localparam int LONG_CYC  = cyc_ceil(LONG_NS, CLK_PS);
    localparam int MAX_WAIT  = max4(SHORT_CYC, LONG_CYC, CAL_TICKS, SETTLE_TICKS);
    localparam int CW        = $clog2(MAX_WAIT + 1);

    act_t           act;
    logic [NCH-1:0] act_ch;
    logic           act_fire;
    logic           tmr_load, tmr_use_tick, tmr_expired;
    logic [CW-1:0]  tmr_val;
    pad_t           pads [NCH];
    xctl_t          xc;

    frz_seq_ctrl #(
        .NCH(NCH), .CW(CW), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC),
        .CAL_TICKS(CAL_TICKS), .SETTLE_TICKS(SETTLE_TICKS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .freeze_req(freeze_req), .thaw_req(thaw_req),
        .tmr_expired(tmr_expired), .act(act), .act_ch(act_ch), .act_fire(act_fire),
        .tmr_load(tmr_load), .tmr_use_tick(tmr_use_tick), .tmr_val(tmr_val),
        .frozen(frozen), .busy(busy), .done(done)
    );

    frz_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(src_sel), .load(tmr_load),
        .use_tick(tmr_use_tick), .load_val(tmr_val), .tick(osc_tick),
        .expired(tmr_expired)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_bank
        frz_pad_bank u_bank (
            .clk(clk), .rst_n(rst_n), .en(act_fire && act_ch[i]),
            .act(act), .pad(pads[i])
        );
        assign slew_n[i]     = pads[i].slew_n;
        assign pullup_n[i]   = pads[i].pullup_n;
        assign tristate_n[i] = pads[i].tristate_n;
        assign bushold_n[i]  = pads[i].bushold_n;
        assign cfg_done[i]   = pads[i].cfg_done;
    end

    frz_ext_ctl u_ext (
        .clk(clk), .rst_n(rst_n), .en(act_fire && act_ch[NCH-1]),
        .act(act), .xc(xc)
    );

    assign reg_rst  = xc.reg_rst;
    assign term_rst = xc.term_rst;
    assign dll_rst  = xc.dll_rst;
    assign cal_en   = xc.cal_en;

    // R10
    pads_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_sel |=> $stable({slew_n, pullup_n, tristate_n, bushold_n, cfg_done, xc}));

endmodule

// File: tb/frz_io_sequencer_test.sv
module frz_io_sequencer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b1;
    logic freeze_req = 1'b0;
    logic thaw_req = 1'b0;
    logic osc_tick = 1'b0;
    logic [3:0] slew_n, pullup_n, tristate_n, bushold_n, cfg_done, frozen;
    logic reg_rst, term_rst, dll_rst, cal_en, busy, done;

    int total = 0;
    int bad = 0;
    int ticks_sent = 0;
    int tc [28];
    int tk [28];
    int done_cnt, busy_gap;
    bit finished = 0;

    localparam logic [27:0] SNAP_FROZEN = 28'hF700000;
    localparam logic [27:0] SNAP_THAWED = 28'h08FFFFF;
    // bit map: slew 0-3, pullup 4-7, tristate 8-11, bushold 12-15, cfg 16-19,
    // reg 20, term 21, dll 22, cal 23, frozen 24-27

    always #2.5 clk = ~clk;

    frz_io_sequencer uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .freeze_req(freeze_req),
        .thaw_req(thaw_req), .osc_tick(osc_tick), .slew_n(slew_n), .pullup_n(pullup_n),
        .tristate_n(tristate_n), .bushold_n(bushold_n), .cfg_done(cfg_done),
        .reg_rst(reg_rst), .term_rst(term_rst), .dll_rst(dll_rst), .cal_en(cal_en),
        .frozen(frozen), .busy(busy), .done(done)
    );

    function automatic logic [27:0] snap();
        return {frozen, cal_en, dll_rst, term_rst, reg_rst,
                cfg_done, bushold_n, tristate_n, pullup_n, slew_n};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // oscillator tick every third cycle
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div++;
            osc_tick = (div % 3 == 0);
            if (osc_tick) ticks_sent++;
        end
    end

    // run one sequence, recording the cycle and tick count of every change
    task automatic run_seq(input bit thaw, input bit poke_other);
        logic [27:0] prev, cur;
        for (int b = 0; b < 28; b++) begin tc[b] = -1; tk[b] = -1; end
        done_cnt = 0; busy_gap = 0;
        prev = snap();
        @(negedge clk);
        if (thaw) thaw_req = 1'b1; else freeze_req = 1'b1;
        @(negedge clk);
        thaw_req = 1'b0; freeze_req = 1'b0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(posedge clk); #1;
            if (poke_other && cyc == 40) begin
                if (thaw) freeze_req = 1'b1; else thaw_req = 1'b1;
            end else begin
                freeze_req = 1'b0; thaw_req = 1'b0;
            end
            cur = snap();
            for (int b = 0; b < 28; b++)
                if (cur[b] != prev[b] && tc[b] < 0) begin tc[b] = cyc; tk[b] = ticks_sent; end
            prev = cur;
            if (done) begin
                done_cnt++;
                chk(!busy, "R8", "busy during done", busy, 0);
                break;
            end
            if (!busy && cyc > 0) busy_gap++;
        end
        chk(done_cnt == 1, "R8", "done seen", done_cnt, 1);
        chk(busy_gap == 0, "R8", "busy low mid-run", busy_gap, 0);
        @(posedge clk); #1;
        chk(!done, "R8", "done width", done, 0);
        repeat (10) begin
            @(posedge clk); #1;
            chk(!busy && !done, "R8", "no restart after done", busy, 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(snap() == SNAP_FROZEN, "R1", "reset outputs", snap(), SNAP_FROZEN);
        chk(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
    endtask

    task automatic t_ignored(input bit thaw, input logic [27:0] exp);
        @(negedge clk);
        if (thaw) thaw_req = 1'b1; else freeze_req = 1'b1;
        @(negedge clk);
        thaw_req = 1'b0; freeze_req = 1'b0;
        repeat (20) begin
            @(posedge clk); #1;
            chk(!busy && snap() == exp, "R9", "request ignored", snap(), exp);
        end
    endtask

    task automatic t_thaw();
        run_seq(1'b1, 1'b1);
        for (int c = 0; c < 3; c++) begin
            chk(tc[12+c] >= 0 && tc[16+c] == tc[12+c], "R4", "hold+cfg together", tc[16+c], tc[12+c]);
            chk(tc[8+c] == tc[4+c], "R4", "pullup+tristate together", tc[8+c], tc[4+c]);
            chk(tc[4+c] - tc[12+c] >= 4, "R4", "hold->weak gap", tc[4+c] - tc[12+c], 4);
            chk(tc[c] - tc[4+c] >= 4, "R4", "weak->slew gap", tc[c] - tc[4+c], 4);
            chk(tc[24+c] == tc[c], "R7", "thaw flag at slew", tc[24+c], tc[c]);
        end
        chk(tc[13] > tc[0] && tc[14] > tc[1], "R7", "plain order", tc[14], tc[1]);
        chk(tc[22] > tc[2], "R7", "ext after plain", tc[22], tc[2]);
        chk(tc[23] - tc[22] >= 8, "R5", "dll->cal gap", tc[23] - tc[22], 8);
        chk(tk[15] - tk[23] >= 1000, "R5", "cal wait ticks", tk[15] - tk[23], 1000);
        chk(tc[19] == tc[15] && tc[21] == tc[15], "R5", "hold/cfg/term together", tc[21], tc[15]);
        chk(tk[7] - tk[15] >= 33, "R6", "settle ticks", tk[7] - tk[15], 33);
        chk(tc[11] == tc[7], "R6", "ext pullup+tristate", tc[11], tc[7]);
        chk(tc[20] - tc[7] >= 8, "R6", "weak->reg gap", tc[20] - tc[7], 8);
        chk(tc[3] - tc[20] >= 8, "R6", "reg->slew gap", tc[3] - tc[20], 8);
        chk(tc[27] == tc[3], "R7", "ext thaw flag", tc[27], tc[3]);
        chk(snap() == SNAP_THAWED, "R8", "mid-run freeze ignored", snap(), SNAP_THAWED);
    endtask

    task automatic t_freeze();
        run_seq(1'b0, 1'b1);
        for (int c = 0; c < 4; c++) begin
            chk(tc[c] >= 0 && tc[4+c] == tc[c] && tc[8+c] == tc[c], "R2", "weak lines together", tc[4+c], tc[c]);
            chk(tc[12+c] - tc[c] >= 4, "R2", "weak->hold gap", tc[12+c] - tc[c], 4);
            chk(tc[16+c] == tc[12+c], "R2", "hold+cfg together", tc[16+c], tc[12+c]);
        end
        for (int c = 0; c < 3; c++) begin
            chk(tc[24+c] == tc[12+c], "R7", "freeze flag at hold", tc[24+c], tc[12+c]);
            chk(tc[c+1] > tc[12+c], "R7", "freeze order", tc[c+1], tc[12+c]);
        end
        chk(tc[20] == tc[15] && tc[21] == tc[15], "R3", "resets with hold", tc[20], tc[15]);
        chk(tc[22] == tc[23] && tc[22] > tc[15], "R3", "dll+cal after hold", tc[22], tc[23]);
        chk(tc[27] == tc[22], "R7", "ext freeze flag", tc[27], tc[22]);
        chk(snap() == SNAP_FROZEN, "R8", "mid-run thaw ignored", snap(), SNAP_FROZEN);
    endtask

    task automatic t_select();
        logic [27:0] held;
        int dseen = 0;
        @(negedge clk);
        src_sel = 1'b0; thaw_req = 1'b1;
        @(negedge clk);
        thaw_req = 1'b0;
        repeat (10) begin
            @(posedge clk); #1;
            chk(!busy && snap() == SNAP_FROZEN, "R10", "deselected request", snap(), SNAP_FROZEN);
        end
        @(negedge clk);
        src_sel = 1'b1; thaw_req = 1'b1;
        @(negedge clk);
        thaw_req = 1'b0;
        repeat (30) @(negedge clk);
        src_sel = 1'b0;
        @(posedge clk); #1;
        held = snap();
        repeat (50) begin
            @(posedge clk); #1;
            chk(snap() == held && busy && !done, "R10", "hold while deselected", snap(), held);
        end
        @(negedge clk);
        src_sel = 1'b1;
        for (int i = 0; i < 20000 && dseen == 0; i++) begin
            @(posedge clk); #1;
            if (done) dseen = 1;
        end
        chk(dseen == 1, "R10", "resumed to done", dseen, 1);
        chk(snap() == SNAP_THAWED, "R10", "resumed result", snap(), SNAP_THAWED);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ignored(1'b0, SNAP_FROZEN);
        t_thaw();
        t_ignored(1'b1, SNAP_THAWED);
        t_freeze();
        t_select();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule